// File: doc/BRIEF.md
# Wash Motor Direction Sequencer

This block turns the drum motor of a washing machine through a fixed, lopsided cycle while the wash timer keeps its run input high. The cycle is: forward for a set number of seconds, a pause, reverse for a set number of seconds, and a second pause. The cycle then starts again at forward. It repeats until run drops. When run drops, the motor stops at once, whatever phase it was in, and the sequencer goes back to idle.

Seconds are counted inside the block by a clock divider. The divider counts `TICK_DIV` system clocks for each second: 50,000,000 at a 50 MHz clock, and a small number in simulation. The divider is held cleared whenever run is low, so every run starts from a whole second. The outputs are three status lamps and two motor commands. The minute countdown, the display and the alarm tone are built elsewhere. They only produce or consume the run level.

Top module: `wash_motor_seq`

## Requirements
- R1: One clock edge after run is first sampled high, the forward phase starts: `motor_fwd`=1 and `status_led`=3'b001. It lasts exactly `FWD_S`*`TICK_DIV` clock cycles.
- R2: After forward, a pause of `GAP_S`*`TICK_DIV` cycles follows (`status_led`=3'b100, both motor commands low). Reverse comes next (`motor_rev`=1, `status_led`=3'b010) for `REV_S`*`TICK_DIV` cycles.
- R3: After reverse, a second pause of `GAP_S`*`TICK_DIV` cycles follows. Forward then starts again, and the cycle repeats for as long as run stays high.
- R4: When run is sampled low at an edge, the block is idle after that edge, whatever the phase.
- R5: While running, exactly one bit of `status_led` is set. Bit 0 is forward, bit 1 is reverse and bit 2 is pause.
- R6: `motor_fwd` and `motor_rev` are never high together. Both are low during a pause, in idle and in reset.
- R7: In idle, `status_led` is 3'b000 and both motor commands are low.
- R8: A run that follows an abort starts with a full forward phase. No part-second or phase progress is carried over from the aborted run.
- R9: Driving `rst_n` low forces idle at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High while the wash timer has time left |
| status_led | output | 3 | One-hot lamps: [0] forward, [1] reverse, [2] pause |
| motor_fwd | output | 1 | Forward drive command |
| motor_rev | output | 1 | Reverse drive command |

## Verification
The outputs decode the phase register directly. Every result is therefore due one clock edge after the input that causes it: a change of run shows one edge later, and a phase change shows one edge after the second tick that completes the phase. The exception is reset, which takes effect within the same cycle. The bench reference model counts the edges at which run was high, converts that count into elapsed seconds and a position in the cycle, and compares all outputs after every edge. Reset is checked one time step after `rst_n` falls, without waiting for a clock edge.

// File: rtl/wms_pkg.sv
package wms_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_FWD   = 3'd1,
    PH_GAP_A = 3'd2,
    PH_REV   = 3'd3,
    PH_GAP_B = 3'd4
  } phase_t;
endpackage

// File: rtl/wms_tick_div.sv
module wms_tick_div #(
  parameter int unsigned TICK_DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // Ticks never outlive the run condition (supports R8)
  assert_no_stale_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tick);
endmodule

// File: rtl/wms_phase_seq.sv
module wms_phase_seq
  import wms_pkg::*;
#(
  parameter int unsigned FWD_S = 20,
  parameter int unsigned GAP_S = 10,
  parameter int unsigned REV_S = 20
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  logic   tick,
  output phase_t phase
);
  localparam int unsigned MAX_S = (FWD_S > REV_S) ? ((FWD_S > GAP_S) ? FWD_S : GAP_S)
                                                  : ((REV_S > GAP_S) ? REV_S : GAP_S);
  localparam int unsigned SW = $clog2(MAX_S + 1);

  logic [SW-1:0] sec_cnt;
  logic [SW-1:0] dur_m1;
  phase_t        nxt_ph;

  always_comb begin
    unique case (phase)
      PH_FWD:   begin dur_m1 = SW'(FWD_S - 1); nxt_ph = PH_GAP_A; end
      PH_GAP_A: begin dur_m1 = SW'(GAP_S - 1); nxt_ph = PH_REV;   end
      PH_REV:   begin dur_m1 = SW'(REV_S - 1); nxt_ph = PH_GAP_B; end
      PH_GAP_B: begin dur_m1 = SW'(GAP_S - 1); nxt_ph = PH_FWD;   end
      default:  begin dur_m1 = '0;             nxt_ph = PH_FWD;   end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      sec_cnt <= '0;
    end else if (!run) begin
      phase   <= PH_IDLE;
      sec_cnt <= '0;
    end else if (phase == PH_IDLE) begin
      phase   <= PH_FWD;
      sec_cnt <= '0;
    end else if (tick) begin
      if (sec_cnt == dur_m1) begin
        phase   <= nxt_ph;
        sec_cnt <= '0;
      end else begin
        sec_cnt <= sec_cnt + 1'b1;
      end
    end
  end

  assert_start_fwd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE && run) |=> phase == PH_FWD);
  assert_abort_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> phase == PH_IDLE);
  assert_hold_no_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && phase != PH_IDLE) |=> $stable(phase));
  assert_rev_after_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && phase == PH_REV && $past(phase) != PH_REV) |-> $past(phase) == PH_GAP_A);
endmodule

// File: rtl/wms_out_map.sv
module wms_out_map
  import wms_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_t     phase,
  output logic [2:0] status_led,
  output logic       motor_fwd,
  output logic       motor_rev
);
  always_comb begin
    status_led = 3'b000;
    motor_fwd  = 1'b0;
    motor_rev  = 1'b0;
    unique case (phase)
      PH_FWD:             begin status_led = 3'b001; motor_fwd = 1'b1; end
      PH_REV:             begin status_led = 3'b010; motor_rev = 1'b1; end
      PH_GAP_A, PH_GAP_B: status_led = 3'b100;
      default:            ;
    endcase
  end

  assert_dir_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(motor_fwd && motor_rev));
  assert_lamp_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> $countones(status_led) == 1);
  assert_idle_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (status_led == 3'b000 && !motor_fwd && !motor_rev));
endmodule

// File: rtl/wash_motor_seq.sv
module wash_motor_seq
  import wms_pkg::*;
#(
  parameter int unsigned TICK_DIV = 50_000_000,
  parameter int unsigned FWD_S    = 20,
  parameter int unsigned GAP_S    = 10,
  parameter int unsigned REV_S    = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  output logic [2:0] status_led,
  output logic       motor_fwd,
  output logic       motor_rev
);
  logic   tick;
  phase_t phase;

  wms_tick_div #(.TICK_DIV(TICK_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick)
  );

  wms_phase_seq #(.FWD_S(FWD_S), .GAP_S(GAP_S), .REV_S(REV_S)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .phase(phase)
  );

  wms_out_map u_map (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .status_led(status_led), .motor_fwd(motor_fwd), .motor_rev(motor_rev)
  );
endmodule

// File: tb/wash_motor_seq_test.sv
`timescale 1ns/1ps
module wash_motor_seq_test;
  localparam int DIV = 3;
  localparam int FS = 20, GS = 10, RS = 20;
  localparam int CYC_S = FS + GS + RS + GS;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic [2:0] status_led;
  logic motor_fwd, motor_rev;
  int errors = 0, checks = 0, cycles = 0;
  int e = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  wash_motor_seq #(.TICK_DIV(DIV), .FWD_S(FS), .GAP_S(GS), .REV_S(RS)) uut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .status_led(status_led), .motor_fwd(motor_fwd), .motor_rev(motor_rev)
  );

  // Reference: edges with run high since the last idle
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) e <= 0;
    else if (run) e <= e + 1;
    else e <= 0;
  end

  task automatic check(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got led=%b fwd=%b rev=%b, expected led=%b fwd=%b rev=%b at cycle %0d",
               req, act[4:2], act[1], act[0], exp[4:2], exp[1], exp[0], cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!done) begin
      int m;
      logic [4:0] exp;
      string req;
      if (e == 0) begin
        exp = 5'b000_0_0; req = rst_n ? "R7" : "R9";
      end else begin
        m = ((e - 1) / DIV) % CYC_S;
        if (m < FS)                begin exp = 5'b001_1_0; req = (e <= FS*DIV) ? "R1" : "R3"; end
        else if (m < FS + GS)      begin exp = 5'b100_0_0; req = "R2"; end
        else if (m < FS + GS + RS) begin exp = 5'b010_0_1; req = "R2"; end
        else                       begin exp = 5'b100_0_0; req = "R3"; end
      end
      check(req, {status_led, motor_fwd, motor_rev}, exp);
      checks++;
      if (motor_fwd && motor_rev) begin
        errors++;
        $display("FAIL R6: got fwd=1 rev=1, expected at most one high");
      end
      if (e != 0) begin
        checks++;
        if ($countones(status_led) != 1) begin
          errors++;
          $display("FAIL R5: got led=%b, expected exactly one bit set", status_led);
        end
      end
    end
  end

  task automatic hold(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    hold(3);
    rst_n = 1'b1;
    hold(5);
    run = 1'b1;                               // R1, R2, R3: two full cycles
    hold(2 * CYC_S * DIV + 20);
    run = 1'b0;                               // R4 abort in forward
    hold(5);
    run = 1'b1;
    hold((FS + GS) * DIV + 10);               // mid reverse
    run = 1'b0;                               // R4 abort in reverse
    hold(4);
    run = 1'b1;                               // R8 restart from full forward
    hold((FS + GS) * DIV + 5);
    @(negedge clk);
    #1 rst_n = 1'b0;                          // R9 asynchronous reset
    #0.5;
    check("R9", {status_led, motor_fwd, motor_rev}, 5'b000_0_0);
    run = 1'b0;
    hold(3);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(20000 * 5);
    done = 1;
    errors++; checks++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule